// File: doc/BRIEF.md
# NAND Page DMA Engine

This engine moves one whole flash page between a NAND device and system memory when a single start bit is set. Software sets two memory base addresses (one for the main data area, one for the spare area), a spare length and a page row address. It then writes a control word that holds the direction, the area enables, the number of address cycles and the target chip. The engine sends the opcode pair and the address cycles itself and waits on the ready/busy line. It moves the bytes through a one-byte memory request port with a valid/ready handshake. At the end it clears the start bit and raises a completion interrupt.

On a read, the engine issues the read opcodes and waits for the device to become ready. It then takes 2048 data bytes followed by the spare bytes and stores them in memory. On a program, it sends the program opcode and address, fetches the bytes from memory in the same order and sends them to the device. It then issues the confirm opcode and waits for ready before it signals completion. The data area always uses the data base address and the spare area uses the spare base address, so the two regions of memory need not be adjacent.

Top module: `nand_page_dma`

## Requirements
- R1: After reset, the start bit (control register index 0, bit 0) reads 0 and interrupt status (register index 7, bit 9) reads 0. irq is 0, nfSel is 0, memReqValid is 0 and no flash strobe (nfCmd, nfAle, nfWr, nfRd) is high.
- R2: A read (control bit 1 = 0) sends opcode 0x00 on nfCmd, then the address cycles on nfAle, then opcode 0x30 on nfCmd. Only after that does it raise nfRd, and it never raises nfRd while nfBusy is high. During a read every memory request is a store (memReqWrite = 1).
- R3: Control bit 7 = 1 gives four address cycles and bit 7 = 0 gives five. The cycles are 0x00 and 0x00 (column, forced to zero whatever is written in bits 15:0 of register 4), then register 4 bits 23:16, then bits 31:24, then register 5 bits 7:0 in the fifth cycle only.
- R4: With both areas enabled, a read stores flash byte k (k < 2048) at data base (register 1) + k. The next spare bytes go to spare base (register 2) + (k − 2048). The spare count is register 3 bits 27:16.
- R5: Control bit 2 enables the data area and bit 3 enables the spare area. A disabled area moves no bytes, so the transfer length is the sum of the enabled areas. With both disabled, the engine still runs the full opcode, address and ready sequence and then completes.
- R6: A program (control bit 1 = 1) sends opcode 0x80 and then the address cycles. It fetches the bytes from memory (memReqWrite = 0) in the R4 address order and drives each fetched byte on nfOut with nfWr. Only after the last byte does it send opcode 0x10 and wait for nfBusy to fall.
- R7: The start bit reads 1 while an operation runs and clears by itself when the operation completes.
- R8: Completion sets interrupt status bit 9. Writing 1 to bit 9 of register index 8 clears it. irq is status bit 9 AND enable bit 9 (register index 6).
- R9: While memReqReady is low, the engine raises neither nfRd nor nfWr. memReqValid stays high and memReqAddr holds its value until the request is accepted.
- R10: Control bits 9:8 pick the chip. While an operation runs and a strobe is high, nfSel is one-hot on that chip; when the engine is idle, nfSel is 0.
- R11: While the start bit is set, writes to registers 0 to 5 are ignored and read-back returns the values in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| irq | output | 1 | Completion interrupt |
| nfSel | output | 4 | One-hot chip select while active |
| nfCmd | output | 1 | Command byte strobe |
| nfAle | output | 1 | Address byte strobe |
| nfWr | output | 1 | Program data byte strobe |
| nfRd | output | 1 | Read data byte strobe (nfIn taken) |
| nfOut | output | 8 | Byte driven to the flash |
| nfIn | input | 8 | Byte from the flash |
| nfBusy | input | 1 | Flash busy (1 = busy) |
| memReqValid | output | 1 | Memory request valid |
| memReqWrite | output | 1 | 1 = store to memory, 0 = fetch |
| memReqAddr | output | 32 | Memory byte address |
| memReqWdata | output | 8 | Store data |
| memReqReady | input | 1 | Memory accepts the request this cycle |
| memRdata | input | 8 | Fetch data, valid with memReqReady |

## Verification
The checks assume three things about the inputs. The flash raises nfBusy no later than the clock edge after the confirm opcode. nfBusy stays low while bytes stream. nfIn changes only after an accepted read strobe. The bench flash model raises busy as soon as it sees the confirm opcode, for a random 3 to 20 cycles. It updates its output byte only on the falling edge after a strobe. The memory model toggles ready at random and returns fetch data combinationally from the request address, which keeps the handshake assumptions true.

// File: rtl/nand_dma_pkg.sv
package nand_dma_pkg;
  localparam int REG_AW = 4;
  localparam logic [REG_AW-1:0] RG_CTRL = 4'd0, RG_DBASE = 4'd1, RG_SBASE = 4'd2,
    RG_LEN = 4'd3, RG_ROW = 4'd4, RG_ROWHI = 4'd5, RG_INTEN = 4'd6,
    RG_INTST = 4'd7, RG_INTCLR = 4'd8;
  localparam int INT_BIT = 9;
  localparam logic [7:0] OP_RD1 = 8'h00, OP_RD2 = 8'h30, OP_PG1 = 8'h80, OP_PG2 = 8'h10;

  typedef enum logic [2:0] {S_IDLE, S_CMD1, S_ADDR, S_CMD2, S_BUSY, S_STREAM} dmaState_t;

  typedef struct packed {
    logic launch;
    logic addrStep;
    logic byteStep;
    logic finish;
  } dmaStrobe_t;
endpackage

// File: rtl/nand_dma_datapath.sv
module nand_dma_datapath import nand_dma_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int PAGE_BYTES = 2048,
  parameter int SPARE_W = 12,
  parameter int CS_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  dmaStrobe_t        strb,
  output logic              startBit,
  output logic              dirWrite,
  output logic              addrLast,
  output logic              streamLast,
  output logic              streamEmpty,
  output logic [7:0]        addrByte,
  output logic [ADDR_W-1:0] memAddr,
  output logic [CS_W-1:0]   csIdx,
  output logic              irq
);
  localparam int CNT_W = $clog2(PAGE_BYTES + (1 << SPARE_W));

  logic dataEn, spareEn, fourAddr, intEn, intStat;
  logic [ADDR_W-1:0] dataBase, spareBase;
  logic [SPARE_W-1:0] spareLen;
  logic [15:0] pageRow;
  logic [7:0] pageHi;
  logic [2:0] addrIdx;
  logic [CNT_W-1:0] byteCnt, dataBytes, totalBytes;

  wire cfgWr = regWrEn && !startBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startBit <= 1'b0; dirWrite <= 1'b0; dataEn <= 1'b0; spareEn <= 1'b0;
      fourAddr <= 1'b0; csIdx <= '0; dataBase <= '0; spareBase <= '0;
      spareLen <= '0; pageRow <= '0; pageHi <= '0; intEn <= 1'b0; intStat <= 1'b0;
    end else begin
      if (cfgWr) begin
        unique case (regAddr)
          RG_CTRL: begin
            startBit <= regWrData[0]; dirWrite <= regWrData[1];
            dataEn <= regWrData[2]; spareEn <= regWrData[3];
            fourAddr <= regWrData[7]; csIdx <= regWrData[8 +: CS_W];
          end
          RG_DBASE: dataBase <= regWrData[ADDR_W-1:0];
          RG_SBASE: spareBase <= regWrData[ADDR_W-1:0];
          RG_LEN:   spareLen <= regWrData[16 +: SPARE_W];
          RG_ROW:   pageRow <= regWrData[31:16];
          RG_ROWHI: pageHi <= regWrData[7:0];
          default: ;
        endcase
      end
      if (regWrEn && regAddr == RG_INTEN) intEn <= regWrData[INT_BIT];
      if (strb.finish) begin
        startBit <= 1'b0;
        intStat <= 1'b1;
      end else if (regWrEn && regAddr == RG_INTCLR && regWrData[INT_BIT]) begin
        intStat <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrIdx <= '0; byteCnt <= '0;
    end else begin
      if (strb.launch) addrIdx <= '0;
      else if (strb.addrStep) addrIdx <= addrIdx + 3'd1;
      if (strb.launch) byteCnt <= '0;
      else if (strb.byteStep) byteCnt <= byteCnt + 1'b1;
    end
  end

  assign dataBytes   = dataEn ? CNT_W'(PAGE_BYTES) : '0;
  assign totalBytes  = dataBytes + (spareEn ? CNT_W'(spareLen) : '0);
  assign streamEmpty = (totalBytes == '0);
  assign streamLast  = (byteCnt == totalBytes - 1'b1);
  assign addrLast    = (addrIdx == (fourAddr ? 3'd3 : 3'd4));
  assign memAddr     = (byteCnt < dataBytes) ? dataBase + ADDR_W'(byteCnt)
                                             : spareBase + ADDR_W'(byteCnt - dataBytes);
  assign irq = intStat && intEn;

  always_comb begin
    unique case (addrIdx)
      3'd2:    addrByte = pageRow[7:0];
      3'd3:    addrByte = pageRow[15:8];
      3'd4:    addrByte = pageHi;
      default: addrByte = 8'h00;
    endcase
  end

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      RG_CTRL: begin
        regRdData[0] = startBit; regRdData[1] = dirWrite; regRdData[2] = dataEn;
        regRdData[3] = spareEn; regRdData[7] = fourAddr; regRdData[8 +: CS_W] = csIdx;
      end
      RG_DBASE: regRdData[ADDR_W-1:0] = dataBase;
      RG_SBASE: regRdData[ADDR_W-1:0] = spareBase;
      RG_LEN:   regRdData[16 +: SPARE_W] = spareLen;
      RG_ROW:   regRdData[31:16] = pageRow;
      RG_ROWHI: regRdData[7:0] = pageHi;
      RG_INTEN: regRdData[INT_BIT] = intEn;
      RG_INTST: regRdData[INT_BIT] = intStat;
      default: ;
    endcase
  end

  p_start_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(startBit) |-> intStat);
  p_int_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intStat) |-> $fell(startBit));
  p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rstN)
    (startBit && $past(startBit)) |-> ($stable(dataBase) && $stable(spareLen) && $stable(pageRow)));
endmodule

// File: rtl/nand_dma_control.sv
module nand_dma_control import nand_dma_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startBit,
  input  logic       dirWrite,
  input  logic       addrLast,
  input  logic       streamLast,
  input  logic       streamEmpty,
  input  logic [7:0] addrByte,
  input  logic       nfBusy,
  input  logic       memReqReady,
  input  logic [7:0] memRdata,
  output dmaStrobe_t strb,
  output logic       nfCmd,
  output logic       nfAle,
  output logic       nfWr,
  output logic       nfRd,
  output logic [7:0] nfOut,
  output logic       memReqValid,
  output logic       memReqWrite,
  output logic       active
);
  dmaState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state; strb = '0;
    nfCmd = 1'b0; nfAle = 1'b0; nfWr = 1'b0; nfRd = 1'b0; nfOut = 8'h00;
    memReqValid = 1'b0;
    unique case (state)
      S_IDLE: if (startBit) begin
        strb.launch = 1'b1;
        nextState = S_CMD1;
      end
      S_CMD1: begin
        nfCmd = 1'b1;
        nfOut = dirWrite ? OP_PG1 : OP_RD1;
        nextState = S_ADDR;
      end
      S_ADDR: begin
        nfAle = 1'b1; nfOut = addrByte; strb.addrStep = 1'b1;
        if (addrLast) nextState = (dirWrite && !streamEmpty) ? S_STREAM : S_CMD2;
      end
      S_CMD2: begin
        nfCmd = 1'b1;
        nfOut = dirWrite ? OP_PG2 : OP_RD2;
        nextState = S_BUSY;
      end
      S_BUSY: if (!nfBusy) begin
        if (dirWrite || streamEmpty) begin
          strb.finish = 1'b1;
          nextState = S_IDLE;
        end else begin
          nextState = S_STREAM;
        end
      end
      S_STREAM: begin
        memReqValid = 1'b1;
        if (dirWrite) nfOut = memRdata;
        if (memReqReady) begin
          strb.byteStep = 1'b1;
          if (dirWrite) nfWr = 1'b1;
          else          nfRd = 1'b1;
          if (streamLast) begin
            if (dirWrite) nextState = S_CMD2;
            else begin
              strb.finish = 1'b1;
              nextState = S_IDLE;
            end
          end
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign memReqWrite = !dirWrite;
  assign active = (state != S_IDLE);

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({nfCmd, nfAle, nfWr, nfRd}));
  p_stall_r9: assert property (@(posedge clk) disable iff (!rstN)
    (nfRd || nfWr) |-> memReqReady);
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid);
endmodule

// File: rtl/nand_page_dma.sv
module nand_page_dma import nand_dma_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int PAGE_BYTES = 2048,
  parameter int SPARE_W = 12,
  parameter int CHIPS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              irq,
  output logic [CHIPS-1:0]  nfSel,
  output logic              nfCmd,
  output logic              nfAle,
  output logic              nfWr,
  output logic              nfRd,
  output logic [7:0]        nfOut,
  input  logic [7:0]        nfIn,
  input  logic              nfBusy,
  output logic              memReqValid,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [7:0]        memReqWdata,
  input  logic              memReqReady,
  input  logic [7:0]        memRdata
);
  localparam int CS_W = $clog2(CHIPS);

  dmaStrobe_t strb;
  logic startBit, dirWrite, addrLast, streamLast, streamEmpty, active;
  logic [7:0] addrByte;
  logic [CS_W-1:0] csIdx;

  nand_dma_datapath #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .SPARE_W(SPARE_W), .CS_W(CS_W)) uDp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .strb(strb), .startBit(startBit), .dirWrite(dirWrite),
    .addrLast(addrLast), .streamLast(streamLast), .streamEmpty(streamEmpty),
    .addrByte(addrByte), .memAddr(memReqAddr), .csIdx(csIdx), .irq(irq));

  nand_dma_control uCtl (
    .clk(clk), .rstN(rstN), .startBit(startBit), .dirWrite(dirWrite), .addrLast(addrLast),
    .streamLast(streamLast), .streamEmpty(streamEmpty), .addrByte(addrByte),
    .nfBusy(nfBusy), .memReqReady(memReqReady), .memRdata(memRdata), .strb(strb),
    .nfCmd(nfCmd), .nfAle(nfAle), .nfWr(nfWr), .nfRd(nfRd), .nfOut(nfOut),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite), .active(active));

  assign memReqWdata = nfIn;

  for (genvar g = 0; g < CHIPS; g++) begin : gSel
    assign nfSel[g] = active && (csIdx == CS_W'(g));
  end

  p_sel_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    (nfCmd || nfAle || nfWr || nfRd) |-> $onehot(nfSel));
  p_sel_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !startBit && !active |-> (nfSel == '0));
  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> $stable(memReqAddr));
endmodule

// File: tb/sim_nand_page_dma.sv
`timescale 1ns/1ps
module sim_nand_page_dma;
  localparam int PAGE = 2048;
  localparam int LOGN = 8192;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic irq, nfCmd, nfAle, nfWr, nfRd, memReqValid, memReqWrite;
  logic [3:0] nfSel;
  logic [7:0] nfOut, memReqWdata, memRdata;
  logic [7:0] nfIn = '0;
  logic nfBusy = 1'b0, memReqReady = 1'b0;
  logic [31:0] memReqAddr;

  always #2 clk = ~clk;

  nand_page_dma u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq), .nfSel(nfSel), .nfCmd(nfCmd), .nfAle(nfAle),
    .nfWr(nfWr), .nfRd(nfRd), .nfOut(nfOut), .nfIn(nfIn), .nfBusy(nfBusy),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
    .memReqWdata(memReqWdata), .memReqReady(memReqReady), .memRdata(memRdata));

  function automatic logic [7:0] memPat(logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] flashPat(int unsigned seed, int k);
    return 8'(seed * 7 + k * 13 + (k >> 8));
  endfunction

  assign memRdata = memPat(memReqAddr);

  int nChecks = 0, nFails = 0, cycles = 0;
  int unsigned opSeed = 0;
  int rdPtr = 0, busyCnt = 0, nCmd = 0, nAddr = 0, nMw = 0, nFw = 0, fwAtCmd2 = -1;
  int selErr = 0, stallErr = 0, holdErr = 0, busyErr = 0, dirErr = 0;
  bit readyMode = 1'b0, prevWait = 1'b0;
  logic [31:0] prevAddr = '0;
  logic [3:0] expSel = '0;
  logic [7:0] cmdLog [4];
  logic [7:0] addrLog [8];
  logic [31:0] mwAddr [LOGN];
  logic [7:0] mwData [LOGN];
  logic [31:0] fwAddr [LOGN];
  logic [7:0] fwData [LOGN];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // flash and memory models: drive at the falling edge, sample 1 ns later
  initial forever begin
    @(negedge clk);
    cycles++;
    if (cycles > 150000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
    nfIn = flashPat(opSeed, rdPtr);
    memReqReady = readyMode ? ($urandom % 100 < 55) : 1'b1;
    if (busyCnt > 0) begin nfBusy = 1'b1; busyCnt--; end
    else nfBusy = 1'b0;
    #1;
    if (rstN) begin
      if ((nfCmd || nfAle || nfWr || nfRd) && nfSel != expSel) selErr++;
      if ((nfRd || nfWr) && !memReqReady) stallErr++;
      if ((nfRd || nfWr) && nfBusy) busyErr++;
      if (prevWait && memReqAddr != prevAddr) holdErr++;
      prevWait = memReqValid && !memReqReady;
      prevAddr = memReqAddr;
      if (nfCmd) begin
        if (nCmd < 4) cmdLog[nCmd] = nfOut;
        nCmd++;
        if (nfOut == 8'h30 || nfOut == 8'h10) begin
          busyCnt = $urandom_range(20, 3);
          nfBusy = 1'b1;
        end
        if (nfOut == 8'h10) fwAtCmd2 = nFw;
      end
      if (nfAle) begin
        if (nAddr < 8) addrLog[nAddr] = nfOut;
        nAddr++;
      end
      if (nfRd) begin
        if (!memReqWrite) dirErr++;
        if (nMw < LOGN) begin mwAddr[nMw] = memReqAddr; mwData[nMw] = memReqWdata; end
        nMw++; rdPtr++;
      end
      if (nfWr) begin
        if (memReqWrite) dirErr++;
        if (nFw < LOGN) begin fwAddr[nFw] = memReqAddr; fwData[nFw] = nfOut; end
        nFw++;
      end
    end
  end

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic runOp(input bit dir, input bit four, input bit dEn, input bit sEn,
                       input int sLen, input int cs, input logic [15:0] row,
                       input logic [7:0] hi, input bit ien, input bit rmode, input bit poke);
    logic [31:0] dBase, sBase, v;
    logic [7:0] expA [5];
    int total, dB, nA, errs, w;
    string tagX;
    dBase = 32'h1000 + ($urandom % 16) * 32'h10;
    sBase = 32'h9000 + ($urandom % 16) * 32'h8;
    dB = dEn ? PAGE : 0;
    total = dB + (sEn ? sLen : 0);
    opSeed = $urandom; rdPtr = 0; readyMode = rmode; expSel = 4'(1 << cs);
    nCmd = 0; nAddr = 0; nMw = 0; nFw = 0; fwAtCmd2 = -1;
    selErr = 0; stallErr = 0; holdErr = 0; busyErr = 0; dirErr = 0;
    regWrite(4'd1, dBase);
    regWrite(4'd2, sBase);
    regWrite(4'd3, 32'(sLen) << 16);
    regWrite(4'd4, {row, 16'hBEEF});
    regWrite(4'd5, {24'h0, hi});
    regWrite(4'd6, 32'(ien) << 9);
    regWrite(4'd0, 32'd1 | (32'(dir) << 1) | (32'(dEn) << 2) | (32'(sEn) << 3)
                   | (32'(four) << 7) | (32'(cs) << 8));
    regRead(4'd0, v);
    chk(v[0] == 1'b1, "R7 start set while running", {31'h0, v[0]}, 32'd1);
    if (poke) begin
      regWrite(4'd1, 32'hDEAD0000);
      regWrite(4'd0, 32'd1 | (32'(!dir) << 1));
    end
    w = 0;
    do begin regRead(4'd0, v); w++; end while (v[0] && w < 40000);
    chk(v[0] == 1'b0, "R7 start cleared on completion", {31'h0, v[0]}, 32'd0);
    // opcode pair
    tagX = dir ? "R6 program opcodes" : "R2 read opcodes";
    chk(nCmd == 2 && cmdLog[0] == (dir ? 8'h80 : 8'h00) && cmdLog[1] == (dir ? 8'h10 : 8'h30),
        tagX, {cmdLog[0], cmdLog[1], 16'(nCmd)}, {(dir ? 8'h80 : 8'h00), (dir ? 8'h10 : 8'h30), 16'd2});
    // address cycles
    nA = four ? 4 : 5;
    expA[0] = 8'h00; expA[1] = 8'h00; expA[2] = row[7:0]; expA[3] = row[15:8]; expA[4] = hi;
    errs = 0;
    for (int i = 0; i < nA && i < nAddr; i++) if (addrLog[i] != expA[i]) errs++;
    chk(nAddr == nA && errs == 0, "R3 address cycles", 32'(nAddr), 32'(nA));
    // byte movement
    errs = 0;
    if (!dir) begin
      for (int k = 0; k < total && k < nMw; k++) begin
        v = (k < dB) ? dBase + 32'(k) : sBase + 32'(k - dB);
        if (mwAddr[k] != v || mwData[k] != flashPat(opSeed, k)) errs++;
      end
      tagX = (dEn && sEn) ? "R4 read placement" : "R5 area enables on read";
      chk(nMw == total && nFw == 0 && errs == 0, tagX, 32'(nMw), 32'(total));
    end else begin
      for (int k = 0; k < total && k < nFw; k++) begin
        v = (k < dB) ? dBase + 32'(k) : sBase + 32'(k - dB);
        if (fwAddr[k] != v || fwData[k] != memPat(v)) errs++;
      end
      chk(nFw == total && nMw == 0 && errs == 0, "R6 program bytes", 32'(nFw), 32'(total));
      chk(fwAtCmd2 == total, "R6 confirm after last byte", 32'(fwAtCmd2), 32'(total));
    end
    chk(busyErr == 0 && dirErr == 0, "R2 no data while busy, request kind", 32'(busyErr + dirErr), 32'd0);
    chk(stallErr == 0 && holdErr == 0, "R9 backpressure", 32'(stallErr + holdErr), 32'd0);
    chk(selErr == 0 && nfSel == 4'h0, "R10 chip select", 32'(selErr), 32'd0);
    regRead(4'd7, v);
    chk(v[9] == 1'b1 && irq == ien, "R8 status and irq on completion", {v[9], irq}, {1'b1, ien});
    regWrite(4'd8, 32'h200);
    regRead(4'd7, v);
    chk(v[9] == 1'b0 && irq == 1'b0, "R8 clear by write", {v[9], irq}, 32'd0);
    if (poke) begin
      regRead(4'd1, v);
      chk(v == dBase, "R11 config write ignored while busy", v, dBase);
    end
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(irq == 1'b0 && nfSel == 4'h0 && !memReqValid && !(nfCmd || nfAle || nfWr || nfRd),
        "R1 outputs after reset", {irq, nfSel, memReqValid}, 32'd0);
    regRead(4'd0, v);
    chk(v == 32'd0, "R1 control after reset", v, 32'd0);
    regRead(4'd7, v);
    chk(v[9] == 1'b0, "R1 status after reset", v, 32'd0);

    runOp(1'b0, 1'b0, 1'b1, 1'b1, 64,  2, 16'hA5C3, 8'h17, 1'b1, 1'b1, 1'b0);
    runOp(1'b0, 1'b1, 1'b0, 1'b1, 100, 1, 16'h1234, 8'h00, 1'b1, 1'b0, 1'b0);
    runOp(1'b0, 1'b0, 1'b0, 1'b0, 0,   3, 16'h0F0F, 8'h3C, 1'b1, 1'b1, 1'b0);
    runOp(1'b1, 1'b0, 1'b1, 1'b1, 16,  0, 16'h8001, 8'h02, 1'b1, 1'b1, 1'b0);
    runOp(1'b1, 1'b1, 1'b1, 1'b0, 40,  3, 16'h7E11, 8'h55, 1'b0, 1'b1, 1'b0);
    runOp(1'b0, 1'b1, 1'b1, 1'b1, 8,   0, 16'h4242, 8'h99, 1'b1, 1'b1, 1'b1);
    for (int r = 0; r < 3; r++) begin
      runOp(1'($urandom), 1'($urandom), 1'($urandom), 1'b1, int'($urandom % 200),
            int'($urandom % 4), 16'($urandom), 8'($urandom), 1'($urandom), 1'b1, r == 1);
    end
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule